// File: doc/BRIEF.md
# Instruction-Table Serial Flash Sequencer

This block drives a single-data-rate serial flash bus (one data line each way, chip select, serial clock) by replaying instructions held in a small on-chip table. The table is split into numbered sequences of fixed length. A read request names a starting sequence and how many sequences follow it. The engine then walks those sequences in ascending order, one instruction at a time. An instruction can send a command byte, shift out address bits, idle the clock for a set number of cycles, read bytes back, or end its sequence. The engine makes no decisions on returned data: it only plays back the programmed timing. A long fixed wait, such as a page-load delay, is therefore built by placing several dummy instructions back to back.

Software loads the table through a write port, one instruction per write. Each instruction is 16 bits. Bits [13:8] hold the opcode: 0 ends the sequence, 1 sends a command byte, 2 sends address bits, 3 inserts dummy clocks, 4 reads bytes. Bits [7:0] hold the operand. Bits [15:14] are reserved and must be zero. The bus runs in SPI mode 0, and its clock is derived from the system clock by a divider parameter.

Top module: `instr_spi_seq`

## Requirements
- R1: A write with `tbl_we_i` high stores `tbl_wdata_i` at table entry `tbl_waddr_i`. The entry index is the sequence number times 8 plus the slot number (0..7). The bits sent on the bus in later accesses follow the stored entries.
- R2: When the block is idle, a request with a valid range raises `busy_o` and pulls `cs_no` low on the next cycle. A request made while `busy_o` is high is ignored.
- R3: A request is rejected when its count is 0 or when start plus count exceeds 16. A rejected request pulses `err_o` for one cycle on the next cycle, leaves `busy_o` low, and causes no chip-select or clock activity.
- R4: Opcode 1 shifts its operand byte out on `mosi_o`, most significant bit first, over 8 clocks.
- R5: Opcode 2 shifts the low N bits of `req_addr_i` out, most significant bit first, where N is the operand. Bit positions at or above 32 are sent as 0.
- R6: Opcode 3 produces N clocks with `mosi_o` held low, where N is the operand.
- R7: Opcode 4 reads N bytes from `miso_i`. Bits are sampled on the rising clock edge, most significant bit first. Each byte appears on `rdata_o` with a one-cycle `rvalid_o` pulse while `busy_o` is high.
- R8: Opcode 0, any unused opcode, or nonzero reserved bits end the current sequence. If no such instruction appears, the sequence ends after slot 7. An instruction whose operand is 0 produces no clocks.
- R9: The requested sequences run in ascending order, and `cs_no` stays low from the first to the last. Back-to-back dummy instructions add up, so nine dummy instructions of 250 give 2250 idle clocks.
- R10: When the last instruction finishes, `cs_no` rises, `busy_o` falls and `done_o` pulses, all in the same cycle. `cs_no` is high whenever the block is idle.
- R11: The serial clock idles low and stays low while `cs_no` is high. Each high phase lasts exactly HALF_DIV system cycles, and `mosi_o` changes only while the clock is low.
- R12: `done_o` and `err_o` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table write enable |
| tbl_waddr_i | input | 7 | Table entry index (sequence*8 + slot) |
| tbl_wdata_i | input | 16 | Instruction word |
| req_i | input | 1 | Read request strobe |
| req_seq_i | input | 4 | First sequence to run |
| req_cnt_i | input | 5 | Number of sequences to run |
| req_addr_i | input | 32 | Address source for address instructions |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Access finished (one cycle) |
| err_o | output | 1 | Request rejected (one cycle) |
| rdata_o | output | 8 | Received byte |
| rvalid_o | output | 1 | Received byte valid (one cycle) |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The assertions assume that the attached device changes `miso_i` only while the serial clock is low. They also assume that the table is written only while `busy_o` is low, because the engine reads instructions live during an access. The bench holds both of these. Its device model drives the next `miso_i` bit shortly after each falling clock edge, and every table write happens between accesses. Random ranges always stay within the table. Invalid ranges and a request made during an access are applied only as directed cases, so that the rejection and ignore paths are each exercised on purpose.

// File: rtl/instr_seq_pkg.sv
`timescale 1ns/1ps
package instr_seq_pkg;
  localparam int BIT_CNT_W = 11;  // up to 255 bytes * 8 bits

  typedef enum logic [5:0] {
    OP_STOP  = 6'd0,
    OP_CMD   = 6'd1,
    OP_ADDR  = 6'd2,
    OP_DUMMY = 6'd3,
    OP_READ  = 6'd4
  } op_e;

  typedef struct packed {
    logic [1:0] rsvd;
    logic [5:0] opc;
    logic [7:0] opd;
  } instr_t;

  typedef enum logic [1:0] {SH_OUT, SH_DUMMY, SH_IN} sh_mode_e;
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RUN} st_e;
endpackage

// File: rtl/instr_table.sv
`timescale 1ns/1ps
// Flop-based instruction store; NUM_SEQ and SLOTS must be powers of two.
module instr_table
  import instr_seq_pkg::*;
#(
  parameter int NUM_SEQ = 16,
  parameter int SLOTS   = 8,
  localparam int SEQ_W  = $clog2(NUM_SEQ),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int AW     = SEQ_W + SLOT_W,
  localparam int DEPTH  = NUM_SEQ * SLOTS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  instr_t            wdata_i,
  input  logic [SEQ_W-1:0]  rd_seq_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output instr_t            rdata_o
);
  instr_t mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[i] <= '0;
      else if (we_i && waddr_i == AW'(i))       mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[{rd_seq_i, rd_slot_i}];
endmodule

// File: rtl/req_check.sv
`timescale 1ns/1ps
module req_check #(
  parameter int NUM_SEQ = 16,
  parameter int SEQ_W   = 4,
  parameter int CNT_W   = 5
) (
  input  logic [SEQ_W-1:0] start_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             ok_o
);
  logic [CNT_W:0] sum;
  assign sum  = (CNT_W+1)'(start_i) + (CNT_W+1)'(cnt_i);
  assign ok_o = (cnt_i != '0) && (sum <= (CNT_W+1)'(NUM_SEQ));
endmodule

// File: rtl/bit_shifter.sv
`timescale 1ns/1ps
// Mode-0 bit engine: HALF_DIV cycles low, HALF_DIV high per bit.
module bit_shifter
  import instr_seq_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int DW       = 32,
  parameter int CNT_W    = BIT_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  sh_mode_e         mode_i,
  input  logic [CNT_W-1:0] nbits_i,
  input  logic [DW-1:0]    word_i,
  input  logic             miso_i,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             fin_o,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_END = DIV_W'(HALF_DIV - 1);
  localparam int IDX_W = (DW > 1) ? $clog2(DW) : 1;

  logic             active_q, phase_q, fin_q, vld_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] rem_q, idx;
  logic [DW-1:0]    word_q;
  sh_mode_e         mode_q;
  logic [6:0]       rx_q;
  logic [7:0]       byte_q;
  logic             tick, in_range;

  assign idx      = rem_q - 1'b1;
  assign in_range = idx < CNT_W'(DW);
  assign tick     = active_q && (div_q == DIV_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      fin_q    <= 1'b0;
      vld_q    <= 1'b0;
      div_q    <= '0;
      rem_q    <= '0;
      word_q   <= '0;
      mode_q   <= SH_DUMMY;
      rx_q     <= '0;
      byte_q   <= '0;
    end else begin
      fin_q <= 1'b0;
      vld_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        phase_q  <= 1'b0;
        div_q    <= '0;
        rem_q    <= nbits_i;
        word_q   <= word_i;
        mode_q   <= mode_i;
      end else if (active_q) begin
        if (!tick) begin
          div_q <= div_q + 1'b1;
        end else begin
          div_q <= '0;
          if (!phase_q) begin
            phase_q <= 1'b1;  // rising edge: sample
            if (mode_q == SH_IN) begin
              rx_q <= {rx_q[5:0], miso_i};
              if (rem_q[2:0] == 3'd1) begin
                byte_q <= {rx_q, miso_i};
                vld_q  <= 1'b1;
              end
            end
          end else begin
            phase_q <= 1'b0;  // falling edge: next bit
            rem_q   <= rem_q - 1'b1;
            if (rem_q == CNT_W'(1)) begin
              active_q <= 1'b0;
              fin_q    <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign sck_o      = phase_q;
  assign mosi_o     = active_q && (mode_q == SH_OUT) && in_range && word_q[idx[IDX_W-1:0]];
  assign fin_o      = fin_q;
  assign byte_o     = byte_q;
  assign byte_vld_o = vld_q;
endmodule

// File: rtl/instr_spi_seq.sv
`timescale 1ns/1ps
module instr_spi_seq
  import instr_seq_pkg::*;
#(
  parameter int NUM_SEQ  = 16,
  parameter int SLOTS    = 8,
  parameter int ADDR_W   = 32,
  parameter int HALF_DIV = 2,
  localparam int SEQ_W   = $clog2(NUM_SEQ),
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int CNT_W   = $clog2(NUM_SEQ + 1),
  localparam int TAW     = SEQ_W + SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_we_i,
  input  logic [TAW-1:0]    tbl_waddr_i,
  input  logic [15:0]       tbl_wdata_i,
  input  logic              req_i,
  input  logic [SEQ_W-1:0]  req_seq_i,
  input  logic [CNT_W-1:0]  req_cnt_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  st_e                    st_q;
  logic [SEQ_W-1:0]       seq_q;
  logic [SLOT_W-1:0]      slot_q;
  logic [CNT_W-1:0]       left_q;
  logic [ADDR_W-1:0]      addr_q;
  logic                   cs_n_q, done_q, err_q;
  instr_t                 ins;
  logic                   req_ok, fin;
  logic                   is_stop, sh_start, last_slot, seq_end, slot_step;
  logic [BIT_CNT_W-1:0]   nbits;
  sh_mode_e               mode;
  logic [ADDR_W-1:0]      word;

  instr_table #(.NUM_SEQ(NUM_SEQ), .SLOTS(SLOTS)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (tbl_we_i),
    .waddr_i   (tbl_waddr_i),
    .wdata_i   (instr_t'(tbl_wdata_i)),
    .rd_seq_i  (seq_q),
    .rd_slot_i (slot_q),
    .rdata_o   (ins)
  );

  req_check #(.NUM_SEQ(NUM_SEQ), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_req_check (
    .start_i (req_seq_i),
    .cnt_i   (req_cnt_i),
    .ok_o    (req_ok)
  );

  bit_shifter #(.HALF_DIV(HALF_DIV), .DW(ADDR_W), .CNT_W(BIT_CNT_W)) u_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (sh_start),
    .mode_i     (mode),
    .nbits_i    (nbits),
    .word_i     (word),
    .miso_i     (miso_i),
    .sck_o      (sck_o),
    .mosi_o     (mosi_o),
    .fin_o      (fin),
    .byte_o     (rdata_o),
    .byte_vld_o (rvalid_o)
  );

  // Instruction decode
  always_comb begin
    nbits   = '0;
    mode    = SH_DUMMY;
    word    = '0;
    is_stop = 1'b0;
    case (ins.opc)
      OP_CMD: begin
        nbits = BIT_CNT_W'(8);
        mode  = SH_OUT;
        word  = ADDR_W'(ins.opd);
      end
      OP_ADDR: begin
        nbits = BIT_CNT_W'(ins.opd);
        mode  = SH_OUT;
        word  = addr_q;
      end
      OP_DUMMY: nbits = BIT_CNT_W'(ins.opd);
      OP_READ: begin
        nbits = BIT_CNT_W'({ins.opd, 3'b000});
        mode  = SH_IN;
      end
      default: is_stop = 1'b1;
    endcase
    if (ins.rsvd != 2'b00) is_stop = 1'b1;
  end

  assign last_slot = slot_q == SLOT_W'(SLOTS - 1);
  assign sh_start  = (st_q == S_FETCH) && !is_stop && (nbits != '0);
  assign seq_end   = ((st_q == S_FETCH) && (is_stop || ((nbits == '0) && last_slot))) ||
                     ((st_q == S_RUN) && fin && last_slot);
  assign slot_step = ((st_q == S_FETCH) && !is_stop && (nbits == '0) && !last_slot) ||
                     ((st_q == S_RUN) && fin && !last_slot);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      seq_q  <= '0;
      slot_q <= '0;
      left_q <= '0;
      addr_q <= '0;
      cs_n_q <= 1'b1;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        S_IDLE: if (req_i) begin
          if (req_ok) begin
            st_q   <= S_FETCH;
            seq_q  <= req_seq_i;
            left_q <= req_cnt_i;
            slot_q <= '0;
            addr_q <= req_addr_i;
            cs_n_q <= 1'b0;
          end else begin
            err_q <= 1'b1;
          end
        end
        S_FETCH: if (sh_start) st_q <= S_RUN;
        S_RUN:   if (fin) st_q <= S_FETCH;
        default: st_q <= S_IDLE;
      endcase
      if (slot_step) slot_q <= slot_q + 1'b1;
      if (seq_end) begin
        if (left_q == CNT_W'(1)) begin
          st_q   <= S_IDLE;
          cs_n_q <= 1'b1;
          done_q <= 1'b1;
        end else begin
          st_q   <= S_FETCH;
          seq_q  <= seq_q + 1'b1;
          left_q <= left_q - 1'b1;
          slot_q <= '0;
        end
      end
    end
  end

  assign busy_o = st_q != S_IDLE;
  assign cs_no  = cs_n_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/instr_spi_seq_chk.sv
`timescale 1ns/1ps
module instr_spi_seq_chk #(
  parameter int NUM_SEQ = 16,
  parameter int SEQ_W   = 4,
  parameter int CNT_W   = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic [SEQ_W-1:0] req_seq_i,
  input logic [CNT_W-1:0] req_cnt_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic             rvalid_o,
  input logic             sck_o,
  input logic             cs_no,
  input logic             mosi_o
);
  logic [CNT_W:0] sum;
  logic           bad;
  assign sum = (CNT_W+1)'(req_seq_i) + (CNT_W+1)'(req_cnt_i);
  assign bad = (req_cnt_i == '0) || (sum > (CNT_W+1)'(NUM_SEQ));

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && !bad) |=> (busy_o && !cs_no));

  assert_reject_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && bad) |=> (err_o && !busy_o && cs_no));

  assert_rvalid_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> busy_o);

  assert_cs_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);

  assert_done_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && cs_no && $past(busy_o)));

  assert_sck_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);

  assert_mosi_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_err_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  assert_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o}));
endmodule

bind instr_spi_seq instr_spi_seq_chk #(.NUM_SEQ(NUM_SEQ), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .req_seq_i (req_seq_i),
  .req_cnt_i (req_cnt_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .rvalid_o  (rvalid_o),
  .sck_o     (sck_o),
  .cs_no     (cs_no),
  .mosi_o    (mosi_o)
);

// File: tb/instr_spi_seq_tb.sv
`timescale 1ns/1ps
module instr_spi_seq_tb;
  localparam int HALF = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tbl_we_i = 1'b0;
  logic [6:0] tbl_waddr_i = '0;
  logic [15:0] tbl_wdata_i = '0;
  logic req_i = 1'b0;
  logic [3:0] req_seq_i = '0;
  logic [4:0] req_cnt_i = '0;
  logic [31:0] req_addr_i = '0;
  logic busy_o, done_o, err_o, rvalid_o, sck_o, cs_no, mosi_o;
  logic [7:0] rdata_o;
  logic miso_i = 1'b0;

  instr_spi_seq #(.HALF_DIV(HALF)) u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [15:0] tbl_m [128];
  logic exp_b [8192];
  logic cap_b [8192];
  logic [7:0] exp_rd [1024];
  logic [7:0] got_rd [1024];
  int exp_n, exp_rn, got_rn, rc;
  int done_cnt, err_cnt, cs_fall, cs_rise, viol, hi_cnt;
  bit busy_seen, done_busy, done_cs, prev_sck, prev_mosi;
  logic [31:0] salt;

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  function automatic logic pat(input int k);
    logic [31:0] h;
    h = (32'(k) * 32'h9E3779B1) ^ salt;
    return h[16] ^ h[5];
  endfunction

  // Device model
  always @(posedge sck_o) begin
    if (rc < 8192) cap_b[rc] = mosi_o;
    rc++;
  end
  always @(negedge sck_o) begin
    #1 miso_i = pat(rc);
  end
  always @(negedge cs_no) cs_fall++;
  always @(posedge cs_no) cs_rise++;

  always @(negedge clk_i) begin
    if (done_o) begin done_cnt++; done_busy = busy_o; done_cs = cs_no; end
    if (err_o) err_cnt++;
    if (busy_o) busy_seen = 1;
    if (rvalid_o && got_rn < 1024) begin got_rd[got_rn] = rdata_o; got_rn++; end
    if (sck_o) hi_cnt++;
    else if (hi_cnt != 0) begin
      if (hi_cnt != HALF) viol++;
      hi_cnt = 0;
    end
    if (sck_o && prev_sck && mosi_o != prev_mosi) viol++;
    prev_sck = sck_o; prev_mosi = mosi_o;
  end

  function automatic logic [15:0] mk(input logic [5:0] opc, input logic [7:0] opd);
    return {2'b00, opc, opd};
  endfunction

  task automatic wr(input int idx, input logic [15:0] w);
    @(negedge clk_i);
    tbl_we_i = 1'b1; tbl_waddr_i = 7'(idx); tbl_wdata_i = w;
    @(negedge clk_i);
    tbl_we_i = 1'b0;
    tbl_m[idx] = w;
  endtask

  task automatic push(input logic b);
    if (exp_n < 8192) exp_b[exp_n] = b;
    exp_n++;
  endtask

  task automatic build_exp(input int start, input int cnt, input logic [31:0] addr);
    exp_n = 0; exp_rn = 0;
    for (int s = start; s < start + cnt; s++) begin
      for (int sl = 0; sl < 8; sl++) begin
        logic [15:0] w;
        logic [7:0] opd;
        w = tbl_m[s*8 + sl];
        opd = w[7:0];
        if (w[15:14] != 0) break;
        if (w[13:8] == 6'd1) begin
          for (int i = 7; i >= 0; i--) push(opd[i]);
        end else if (w[13:8] == 6'd2) begin
          for (int i = int'(opd) - 1; i >= 0; i--) push(i < 32 ? addr[i] : 1'b0);
        end else if (w[13:8] == 6'd3) begin
          for (int i = 0; i < int'(opd); i++) push(1'b0);
        end else if (w[13:8] == 6'd4) begin
          for (int b = 0; b < int'(opd); b++) begin
            logic [7:0] v;
            for (int i = 0; i < 8; i++) v[7-i] = pat(exp_n + i);
            if (exp_rn < 1024) exp_rd[exp_rn] = v;
            exp_rn++;
            for (int i = 0; i < 8; i++) push(1'b0);
          end
        end else break;
      end
    end
  endtask

  task automatic clr_mon();
    rc = 0; done_cnt = 0; err_cnt = 0; cs_fall = 0; cs_rise = 0; viol = 0;
    got_rn = 0; busy_seen = 0; done_busy = 1; done_cs = 0;
  endtask

  task automatic run_txn(input string tag, input int start, input int cnt,
                         input logic [31:0] addr, input bit poke);
    int mism, rdm, n;
    salt = $urandom;
    clr_mon();
    miso_i = pat(0);
    build_exp(start, cnt, addr);
    @(negedge clk_i);
    req_i = 1'b1; req_seq_i = 4'(start); req_cnt_i = 5'(cnt); req_addr_i = addr;
    @(negedge clk_i);
    req_i = 1'b0; req_addr_i = ~addr;
    if (poke) begin
      repeat (100) @(negedge clk_i);
      req_i = 1'b1; req_seq_i = 4'd0; req_cnt_i = 5'd1;
      @(negedge clk_i);
      req_i = 1'b0;
    end
    n = 0;
    while (done_cnt == 0 && n < 40000) begin @(negedge clk_i); n++; end
    repeat (6) @(negedge clk_i);
    mism = 0;
    for (int k = 0; k < exp_n && k < 8192 && k < rc; k++) if (cap_b[k] !== exp_b[k]) mism++;
    rdm = 0;
    for (int k = 0; k < exp_rn && k < got_rn && k < 1024; k++) if (got_rd[k] !== exp_rd[k]) rdm++;
    chk(done_cnt == 1, {tag, " R10 R12 done pulses"}, done_cnt, 1);
    chk(!done_busy && done_cs, {tag, " R10 busy/cs at done"}, {done_busy, done_cs}, 1);
    chk(rc == exp_n, {tag, " R8 R9 clock count"}, rc, exp_n);
    chk(mism == 0, {tag, " R1 R4 R5 R6 mosi mismatches"}, mism, 0);
    chk(got_rn == exp_rn && rdm == 0, {tag, " R7 read bytes"}, got_rn*1000 + rdm, exp_rn*1000);
    chk(cs_fall == 1 && cs_rise == 1, {tag, " R9 R2 cs edges"}, cs_fall*10 + cs_rise, 11);
    chk(viol == 0, {tag, " R11 clock phase"}, viol, 0);
  endtask

  task automatic run_bad(input int start, input int cnt);
    clr_mon();
    @(negedge clk_i);
    req_i = 1'b1; req_seq_i = 4'(start); req_cnt_i = 5'(cnt);
    @(negedge clk_i);
    req_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk(err_cnt == 1, "R3 R12 err pulse", err_cnt, 1);
    chk(!busy_seen && cs_fall == 0 && rc == 0, "R3 no bus activity",
        int'(busy_seen) + cs_fall + rc, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      finished = 1;
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) tbl_m[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cs_no == 1'b1, "R10 reset cs_no", cs_no, 1);
    chk(sck_o == 1'b0, "R11 reset sck", sck_o, 0);
    chk(busy_o == 1'b0, "R2 reset busy", busy_o, 0);
    chk(done_o == 1'b0 && err_o == 1'b0, "R12 reset pulses", {done_o, err_o}, 0);

    // Page-style access: three chained sequences
    wr(0, mk(1, 8'h13)); wr(1, mk(2, 24)); wr(2, mk(0, 0));
    wr(8, mk(1, 8'h0F)); wr(9, mk(1, 8'hC0)); wr(10, mk(4, 1)); wr(11, mk(0, 0));
    wr(16, mk(1, 8'h03)); wr(17, mk(2, 16)); wr(18, mk(3, 8)); wr(19, mk(4, 4)); wr(20, mk(0, 0));
    run_txn("page", 0, 3, 32'hA5C3_1E7B, 0);
    // Address wider than 32 bits: zero padding
    wr(24, mk(2, 40)); wr(25, mk(0, 0));
    run_txn("R5 wide addr", 3, 1, 32'hF00D_BEEF, 0);
    // Long wait: 9 x 250 dummy clocks, full sequence rolls over at slot 7; busy poke ignored
    for (int i = 0; i < 8; i++) wr(48 + i, mk(3, 250));
    wr(56, mk(3, 250)); wr(57, mk(1, 8'h55)); wr(58, mk(0, 0));
    run_txn("R9 R2 long wait", 6, 2, 32'h0, 1);
    chk(exp_n == 2258, "R9 dummy total", exp_n, 2258);
    // Zero operands, unknown opcode, reserved bits
    wr(120, mk(1, 8'h9F)); wr(121, mk(3, 0)); wr(122, mk(4, 0)); wr(123, mk(2, 0));
    wr(124, mk(1, 8'h11)); wr(125, mk(6'h2A, 8'h77)); wr(126, mk(1, 8'hEE));
    run_txn("R8 skip/stop", 15, 1, 32'h1234_5678, 0);
    wr(112, 16'h4105); wr(113, mk(1, 8'h22));
    run_txn("R8 reserved bits", 14, 1, 32'h0, 0);
    // Rejected ranges
    run_bad(15, 2);
    run_bad(0, 0);
    run_bad(10, 7);

    for (int t = 0; t < 24; t++) begin
      int st, cn, mx;
      st = $urandom_range(0, 15);
      mx = (16 - st) < 3 ? (16 - st) : 3;
      cn = $urandom_range(1, mx);
      for (int s = st; s < st + cn; s++) begin
        for (int sl = 0; sl < 8; sl++) begin
          int r;
          r = $urandom_range(0, 19);
          if (r < 5)       wr(s*8 + sl, mk(1, 8'($urandom)));
          else if (r < 9)  wr(s*8 + sl, mk(2, 8'($urandom_range(0, 34))));
          else if (r < 13) wr(s*8 + sl, mk(3, 8'($urandom_range(0, 10))));
          else if (r < 17) wr(s*8 + sl, mk(4, 8'($urandom_range(0, 2))));
          else if (r < 19) wr(s*8 + sl, mk(0, 0));
          else             wr(s*8 + sl, mk(6'h3F, 8'($urandom)));
        end
      end
      run_txn("random", st, cn, $urandom, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule